// File: doc/BRIEF.md
# Byte-Aligning Instruction Prefetch Buffer

This block sits between a 32-bit program memory port and the decode stage of a CPU whose opcodes are one byte wide and whose instructions are 1 to 4 bytes long. It keeps an 8-byte queue of upcoming instruction bytes. The opcode is always at position 0 and the operand bytes follow it. The first four positions are offered to the decoder together with a valid flag and the number of bytes held.

Memory is always read one aligned 4-byte word at a time. A byte-granular shifter drops the bytes of the word that lie before the program counter and places the rest directly behind the bytes already held. When the decoder consumes an instruction, the queue moves toward position 0 by the instruction's length, and a word may be merged in the same cycle. A redirect (taken branch, jump, call, return) empties the queue. It also restarts fetching at the aligned word that holds the new program counter. A memory response that was already on its way when the redirect arrived is thrown away.

Top module: `pfq_align_top`

## Requirements
- R1: After reset the byte count is 0 and `dec_valid_o` is low. The fetch address is 0 and a request is raised at once.
- R2: Every request address has bits 1:0 equal to 0. A redirect loads the fetch address with the new PC with bits 1:0 cleared. Each accepted request advances the fetch address by 4.
- R3: In the first word fetched after a redirect to PC p, the bytes below offset p[1:0] are dropped. The byte at address p arrives at position 0.
- R4: Byte k of a fetched word (bits 8k+7:8k of `mem_rdata_i`, address = word address + k) lands at position (count after consume) + k - skip, where skip is the number of leading bytes dropped.
- R5: A consume of length L (1 to 4, never more than the count) removes positions 0 to L-1. The byte at position i+L moves to position i.
- R6: The next count equals the old count, minus the consumed length, plus the useful bytes of a response taken in that cycle, capped at 8.
- R7: A request is raised only when no request is outstanding, no redirect is present, and the free slots (8 minus count) are at least the useful bytes of the next word.
- R8: The cycle after a redirect the count is 0. A consume or a response in the redirect cycle has no effect.
- R9: A response to a request accepted before a redirect does not change the count or the bytes.
- R10: `dec_valid_o` is high exactly when the count is non-zero. Position i of the queue is driven on `dec_bytes_o` bits 8i+7:8i for i = 0 to 3.
- R11: After a request is accepted, no new request is raised until its response has arrived.
- R12: Without a consume or a redirect, the byte at position 0 does not change while the queue is non-empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| redirect_i | input | 1 | Change of program flow: flush and refetch |
| redirect_pc_i | input | 32 | Target PC of the redirect |
| consume_i | input | 1 | Decoder removes one instruction |
| consume_len_i | input | 3 | Length of the consumed instruction, 1 to 4 |
| dec_valid_o | output | 1 | At least one byte held |
| dec_count_o | output | 4 | Number of valid bytes, 0 to 8 |
| dec_bytes_o | output | 32 | Positions 0 to 3, position 0 in bits 7:0 |
| mem_req_o | output | 1 | Word request |
| mem_addr_o | output | 32 | Word-aligned request address |
| mem_gnt_i | input | 1 | Request accepted |
| mem_rvalid_i | input | 1 | Response word present |
| mem_rdata_i | input | 32 | Response word, lowest address in bits 7:0 |

## Verification
The checker watches, on every cycle, the alignment of request addresses and their step of 4 per accepted word. It also checks the load of the aligned target on a redirect, the empty queue after a flush, the single outstanding request, and the count drop on a consume without a merge. It further checks that position 0 holds still when nothing is consumed. Only the bench's scenarios can show that the right bytes land in the right slots: the dropped leading bytes of an unaligned target, and merges that coincide with consumes. The same holds for discarding responses that were in flight across a redirect, and for stopping fetches when the queue has no room. These need the memory contents and the history of requests, which the bench tracks in its own model.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;

    // Useful bytes of a word when 'skip' leading bytes are dropped.
    function automatic int useful_bytes(input int word_bytes, input int skip);
        return word_bytes - skip;
    endfunction
endpackage

// File: rtl/pfq_fetch_ctrl.sv
module pfq_fetch_ctrl #(
    parameter int AW         = 32,
    parameter int BUF_BYTES  = 8,
    parameter int WORD_BYTES = 4,
    parameter int CW         = 4,
    parameter int OW         = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          redirect_i,
    input  logic [AW-1:0] redirect_pc_i,
    input  logic [CW-1:0] count_i,
    input  logic          mem_gnt_i,
    input  logic          mem_rvalid_i,
    output logic          mem_req_o,
    output logic [AW-1:0] mem_addr_o,
    output logic          take_o,
    output logic [OW-1:0] take_skip_o
);
    import pfq_pkg::*;

    typedef struct packed {
        logic [AW-1:0] addr;   // next word to request
        logic [OW-1:0] skip;   // leading bytes to drop in that word
        logic [OW-1:0] rskip;  // skip of the word in flight
        logic          busy;   // a request is outstanding
        logic          drop;   // the outstanding response is stale
    } fc_state_t;

    fc_state_t st_q, st_d;
    logic accept, resp;
    int   free_s, need_s;

    always_comb begin
        free_s = BUF_BYTES - int'(count_i);
        need_s = useful_bytes(WORD_BYTES, int'(st_q.skip));

        mem_req_o   = !st_q.busy && !redirect_i && (free_s >= need_s);
        mem_addr_o  = st_q.addr;
        accept      = mem_req_o && mem_gnt_i;
        resp        = st_q.busy && mem_rvalid_i;
        take_o      = resp && !st_q.drop && !redirect_i;
        take_skip_o = st_q.rskip;

        st_d = st_q;
        if (resp) begin
            st_d.busy = 1'b0;
            st_d.drop = 1'b0;
        end
        if (accept) begin
            st_d.busy  = 1'b1;
            st_d.addr  = st_q.addr + AW'(WORD_BYTES);
            st_d.rskip = st_q.skip;
            st_d.skip  = '0;
        end
        if (redirect_i) begin
            st_d.addr = {redirect_pc_i[AW-1:OW], {OW{1'b0}}};
            st_d.skip = redirect_pc_i[OW-1:0];
            if (st_q.busy && !mem_rvalid_i) begin
                st_d.drop = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pfq_merge.sv
module pfq_merge #(
    parameter int BUF_BYTES  = 8,
    parameter int WORD_BYTES = 4,
    parameter int CW         = 4,
    parameter int OW         = 2,
    parameter int LW         = 3
) (
    input  pfq_pkg::byte_t [BUF_BYTES-1:0]  buf_i,
    input  logic [CW-1:0]                   count_i,
    input  logic [LW-1:0]                   len_i,
    input  logic                            take_i,
    input  logic [OW-1:0]                   skip_i,
    input  pfq_pkg::byte_t [WORD_BYTES-1:0] word_i,
    output pfq_pkg::byte_t [BUF_BYTES-1:0]  buf_o,
    output logic [CW-1:0]                   count_o
);
    import pfq_pkg::*;

    localparam int IW = $clog2(BUF_BYTES);

    int keep_s, add_s, tot_s;

    // Bytes kept after the consume, then useful bytes appended behind them.
    always_comb begin
        keep_s = int'(count_i) - int'(len_i);
        if (keep_s < 0) begin
            keep_s = 0;
        end
        add_s = take_i ? useful_bytes(WORD_BYTES, int'(skip_i)) : 0;
        tot_s = keep_s + add_s;
        if (tot_s > BUF_BYTES) begin
            tot_s = BUF_BYTES;
        end
        count_o = CW'(tot_s);
    end

    // Per slot: shifted old byte below the kept count, else the fetch word
    // shifted by (keep - skip), which spans -3..+7 positions.
    for (genvar g = 0; g < BUF_BYTES; g++) begin : g_slot
        byte_t slot;
        int    src, wix;
        always_comb begin
            src  = g + int'(len_i);
            wix  = g - keep_s + int'(skip_i);
            slot = '0;
            if (g < keep_s) begin
                if (src < BUF_BYTES) begin
                    slot = buf_i[src[IW-1:0]];
                end
            end else if (take_i && (wix >= 0) && (wix < WORD_BYTES)) begin
                slot = word_i[wix[OW-1:0]];
            end
        end
        assign buf_o[g] = slot;
    end
endmodule

// File: rtl/pfq_align_top.sv
module pfq_align_top #(
    parameter  int AW         = 32,
    parameter  int BUF_BYTES  = 8,
    parameter  int WORD_BYTES = 4,
    parameter  int MAX_LEN    = 4,
    parameter  int DEC_BYTES  = 4,
    localparam int CW         = $clog2(BUF_BYTES + 1),
    localparam int LW         = $clog2(MAX_LEN + 1),
    localparam int OW         = $clog2(WORD_BYTES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    redirect_i,
    input  logic [AW-1:0]           redirect_pc_i,
    input  logic                    consume_i,
    input  logic [LW-1:0]           consume_len_i,
    output logic                    dec_valid_o,
    output logic [CW-1:0]           dec_count_o,
    output logic [DEC_BYTES*8-1:0]  dec_bytes_o,
    output logic                    mem_req_o,
    output logic [AW-1:0]           mem_addr_o,
    input  logic                    mem_gnt_i,
    input  logic                    mem_rvalid_i,
    input  logic [WORD_BYTES*8-1:0] mem_rdata_i
);
    import pfq_pkg::*;

    typedef struct packed {
        byte_t [BUF_BYTES-1:0] bytes;
        logic  [CW-1:0]        count;
    } ib_state_t;

    ib_state_t             st_q, st_d;
    byte_t [BUF_BYTES-1:0] mrg_bytes;
    logic  [CW-1:0]        mrg_count;
    logic  [LW-1:0]        eat_len;
    logic                  resp_take;
    logic  [OW-1:0]        resp_skip;
    byte_t [WORD_BYTES-1:0] word_b;

    assign eat_len = (consume_i && !redirect_i) ? consume_len_i : '0;

    for (genvar w = 0; w < WORD_BYTES; w++) begin : g_word
        assign word_b[w] = mem_rdata_i[w*8 +: 8];
    end

    pfq_fetch_ctrl #(
        .AW(AW), .BUF_BYTES(BUF_BYTES), .WORD_BYTES(WORD_BYTES), .CW(CW), .OW(OW)
    ) u_fetch (
        .clk          (clk),
        .rst_n        (rst_n),
        .redirect_i   (redirect_i),
        .redirect_pc_i(redirect_pc_i),
        .count_i      (st_q.count),
        .mem_gnt_i    (mem_gnt_i),
        .mem_rvalid_i (mem_rvalid_i),
        .mem_req_o    (mem_req_o),
        .mem_addr_o   (mem_addr_o),
        .take_o       (resp_take),
        .take_skip_o  (resp_skip)
    );

    pfq_merge #(
        .BUF_BYTES(BUF_BYTES), .WORD_BYTES(WORD_BYTES), .CW(CW), .OW(OW), .LW(LW)
    ) u_merge (
        .buf_i  (st_q.bytes),
        .count_i(st_q.count),
        .len_i  (eat_len),
        .take_i (resp_take),
        .skip_i (resp_skip),
        .word_i (word_b),
        .buf_o  (mrg_bytes),
        .count_o(mrg_count)
    );

    always_comb begin
        st_d = st_q;
        if (redirect_i) begin
            st_d.bytes = '0;
            st_d.count = '0;
        end else begin
            st_d.bytes = mrg_bytes;
            st_d.count = mrg_count;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dec_valid_o = (st_q.count != '0);
    assign dec_count_o = st_q.count;

    for (genvar i = 0; i < DEC_BYTES; i++) begin : g_dec
        assign dec_bytes_o[i*8 +: 8] = st_q.bytes[i];
    end
endmodule

// File: rtl/pfq_align_chk.sv
module pfq_align_chk #(
    parameter int AW         = 32,
    parameter int BUF_BYTES  = 8,
    parameter int WORD_BYTES = 4,
    parameter int CW         = 4,
    parameter int LW         = 3,
    parameter int OW         = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          redirect_i,
    input logic [AW-1:0] redirect_pc_i,
    input logic          consume_i,
    input logic [LW-1:0] consume_len_i,
    input logic [CW-1:0] dec_count_o,
    input logic [7:0]    op_byte,
    input logic          dec_valid_o,
    input logic          mem_req_o,
    input logic [AW-1:0] mem_addr_o,
    input logic          mem_gnt_i,
    input logic          take
);
    logic [AW-1:0] tgt_al;
    assign tgt_al = {redirect_pc_i[AW-1:OW], {OW{1'b0}}};

    a_r6_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
        dec_count_o <= CW'(BUF_BYTES));

    a_r2_aligned_req: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> (mem_addr_o[OW-1:0] == '0));

    a_r2_step_four: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_gnt_i) |=> (mem_addr_o == $past(mem_addr_o) + AW'(WORD_BYTES)));

    a_r2_redirect_target: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_i |=> (mem_addr_o == $past(tgt_al)));

    a_r8_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_i |=> (dec_count_o == '0 && !dec_valid_o));

    a_r11_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_gnt_i) |=> !mem_req_o);

    a_r5_consume_count: assert property (@(posedge clk) disable iff (!rst_n)
        (consume_i && !redirect_i && !take) |=>
            (dec_count_o == $past(dec_count_o) - CW'($past(consume_len_i))));

    a_r12_opcode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!consume_i && !redirect_i && dec_valid_o) |=> (op_byte == $past(op_byte)));
endmodule

bind pfq_align_top pfq_align_chk #(
    .AW(AW), .BUF_BYTES(BUF_BYTES), .WORD_BYTES(WORD_BYTES), .CW(CW), .LW(LW), .OW(OW)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .redirect_i   (redirect_i),
    .redirect_pc_i(redirect_pc_i),
    .consume_i    (consume_i),
    .consume_len_i(consume_len_i),
    .dec_count_o  (dec_count_o),
    .op_byte      (dec_bytes_o[7:0]),
    .dec_valid_o  (dec_valid_o),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_gnt_i    (mem_gnt_i),
    .take         (resp_take)
);

// File: tb/sim_pfq_align_top.sv
`timescale 1ns/1ps
module sim_pfq_align_top;
    localparam int AW = 32;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        redirect_i;
    logic [31:0] redirect_pc_i;
    logic        consume_i;
    logic [2:0]  consume_len_i;
    logic        dec_valid_o;
    logic [3:0]  dec_count_o;
    logic [31:0] dec_bytes_o;
    logic        mem_req_o;
    logic [31:0] mem_addr_o;
    logic        mem_gnt_i;
    logic        mem_rvalid_i;
    logic [31:0] mem_rdata_i;

    always #2.5 clk = ~clk;

    pfq_align_top u0 (
        .clk(clk), .rst_n(rst_n),
        .redirect_i(redirect_i), .redirect_pc_i(redirect_pc_i),
        .consume_i(consume_i), .consume_len_i(consume_len_i),
        .dec_valid_o(dec_valid_o), .dec_count_o(dec_count_o), .dec_bytes_o(dec_bytes_o),
        .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_gnt_i(mem_gnt_i),
        .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i)
    );

    int checks = 0;
    int fails  = 0;

    // Reference model state
    int          count_m, epoch, cyc;
    logic [31:0] head_pc, stream_pc, next_fetch;
    bit          pend;
    int          pend_epoch, pend_due, pend_useful;
    logic [31:0] pend_addr;
    bit          prev_redir, prev_stale, prev_cons;

    function automatic logic [7:0] mbyte(input logic [31:0] a);
        return a[7:0] ^ {a[10:8], 5'b0} ^ 8'h3C;
    endfunction

    function automatic logic [31:0] mword(input logic [31:0] a);
        return {mbyte(a + 3), mbyte(a + 2), mbyte(a + 1), mbyte(a)};
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int mode);
        bit          redir, cons, rv;
        logic [31:0] pc;
        int          len, lim, useful_next;
        bit          exp_req;
        string       ctag, btag;
        @(negedge clk);
        cyc++;
        ctag = prev_stale ? "R9 stale response ignored" :
               prev_redir ? "R8 flush empties" : "R6 count";
        chk(int'(dec_count_o) == count_m, ctag, dec_count_o, count_m);
        chk(dec_valid_o == (count_m > 0), "R10 valid", dec_valid_o, count_m > 0);
        for (int i = 0; i < 4 && i < count_m; i++) begin
            if (head_pc == stream_pc && stream_pc[1:0] != 2'b00) btag = "R3 unaligned start byte";
            else if (!prev_cons && i == 0) btag = "R12 R4 opcode byte";
            else btag = "R4 R5 R10 byte position";
            chk(dec_bytes_o[i*8 +: 8] == mbyte(head_pc + i), btag,
                dec_bytes_o[i*8 +: 8], mbyte(head_pc + i));
        end

        redir = 1'b0;
        pc    = 32'h0;
        cons  = 1'b0;
        len   = 0;
        case (mode)
            0: ;
            1: redir = ($urandom % 40) == 0;
            2: redir = ($urandom % 5) == 0;
            3: redir = ($urandom % 9) == 0;
            5: begin redir = 1'b1; pc = 32'h0000_0203; end
            default: ;
        endcase
        if (redir && mode != 5) pc = 32'h100 + ($urandom % 64);
        if (mode != 0 && mode != 5 && count_m > 0 && ($urandom % 3) != 0) begin
            cons = 1'b1;
            lim  = (count_m < 4) ? count_m : 4;
            len  = 1 + int'($urandom % lim);
        end
        rv = pend && (cyc == pend_due);

        redirect_i    = redir;
        redirect_pc_i = pc;
        consume_i     = cons;
        consume_len_i = 3'(len);
        mem_gnt_i     = (mode == 2) ? (($urandom % 2) == 0) : (($urandom % 8) != 0);
        mem_rvalid_i  = rv;
        mem_rdata_i   = rv ? mword(pend_addr) : 32'hDEAD_BEEF;
        #1;

        useful_next = 32'(next_fetch + 4 - ((next_fetch > stream_pc) ? next_fetch : stream_pc));
        exp_req = !pend && !redir && ((8 - count_m) >= useful_next);
        chk(mem_req_o == exp_req, "R7 R11 request rule", mem_req_o, exp_req);
        if (mem_req_o && mem_gnt_i)
            chk(mem_addr_o == next_fetch, "R2 fetch address", mem_addr_o, next_fetch);

        prev_redir = redir;
        prev_stale = 1'b0;
        prev_cons  = cons && !redir;
        if (redir) begin
            count_m    = 0;
            head_pc    = pc;
            stream_pc  = pc;
            next_fetch = {pc[31:2], 2'b00};
            epoch++;
            if (rv) pend = 1'b0;
        end else begin
            if (cons) begin
                count_m -= len;
                head_pc += 32'(len);
            end
            if (rv) begin
                if (pend_epoch == epoch) count_m += pend_useful;
                else prev_stale = 1'b1;
                pend = 1'b0;
            end
            if (mem_req_o && mem_gnt_i) begin
                pend        = 1'b1;
                pend_epoch  = epoch;
                pend_due    = cyc + 1 + int'($urandom % 3);
                pend_useful = useful_next;
                pend_addr   = next_fetch;
                next_fetch += 32'd4;
            end
        end
    endtask

    initial begin
        rst_n = 1'b0;
        redirect_i = 1'b0; redirect_pc_i = '0; consume_i = 1'b0; consume_len_i = '0;
        mem_gnt_i = 1'b0; mem_rvalid_i = 1'b0; mem_rdata_i = '0;
        count_m = 0; epoch = 0; cyc = 0;
        head_pc = '0; stream_pc = '0; next_fetch = '0;
        pend = 1'b0; pend_epoch = 0; pend_due = 0; pend_useful = 0; pend_addr = '0;
        prev_redir = 1'b0; prev_stale = 1'b0; prev_cons = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(dec_count_o == 4'd0, "R1 reset count", dec_count_o, 0);
        chk(dec_valid_o == 1'b0, "R1 reset valid", dec_valid_o, 0);
        rst_n = 1'b1;
        #1;
        chk(mem_req_o == 1'b1, "R1 request after reset", mem_req_o, 1);
        chk(mem_addr_o == 32'h0, "R1 reset fetch address", mem_addr_o, 0);
        // unaligned redirect, then fill without consuming until fetch stops
        step(5);
        repeat (30) step(0);
        chk(dec_count_o == 4'd5, "R7 fill stops at five", dec_count_o, 5);
        repeat (2000) step(1);
        repeat (2000) step(2);
        repeat (2000) step(3);
        repeat (40) step(0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule